// File: doc/BRIEF.md
# Miss Tracking Register Pool with Demand Reservation

This block keeps track of outstanding cache misses in a fixed pool of tracking entries. Each entry holds a valid bit and the block address of a miss. A demand miss from the processor and a prefetch can each request an entry. A completion port releases an entry by its index. A lookup port reports whether a block address is already outstanding, and which entry holds it, so that a second miss to the same block can be merged instead of issued again.

There are two occupancy limits. The first is the ordinary capacity check, which turns on the full flag and refuses demand misses. It keeps a margin of `ACC_RSV` entries: the physical pool is `N_CFG + ACC_RSV - 1` entries deep, and the full flag goes high once the occupancy passes the physical size minus that margin. The second limit is stricter and applies to prefetches only. It holds back a further `DEM_RSV` entries, so a prefetcher running ahead can never fill the pool and make the processor's own misses wait. A prefetch is considered only in a cycle with no demand request, and only while prefetch admission is open. Otherwise the prefetch is dropped and the block raises a reject pulse in that same cycle. With `DEM_RSV = 0`, as used for a write buffer, the prefetch limit becomes the plain capacity margin.

Top module: `mshr_pool`

## Requirements
- R1: The pool holds PHYS = N_CFG + ACC_RSV - 1 entries. An accepted allocation takes the lowest-indexed entry that is not valid, and `alloc_idx` shows that index in the same cycle. At most one allocation happens per cycle.
- R2: `full` is high exactly when the occupancy is greater than PHYS - ACC_RSV. `dem_req_ready` is the inverse of `full`.
- R3: `can_prefetch` is high exactly when the occupancy is less than PHYS - ACC_RSV - DEM_RSV.
- R4: A demand request presented while `full` is high sees `dem_req_ready` low and changes no entry and no occupancy.
- R5: A prefetch is accepted only when `can_prefetch` is high and `dem_req_valid` is low. In every other cycle where `pf_req_valid` is high, `pf_reject` is high in that same cycle and no entry is allocated.
- R6: A release of a valid entry clears that entry and lowers the occupancy by one. A release naming an entry that is not valid, or an index of PHYS or more, is ignored.
- R7: An allocation and a release in the same cycle leave the occupancy unchanged. The entry being released is not handed out in that cycle.
- R8: `lookup_hit` is high when some valid entry holds `lookup_blk`. `lookup_idx` then gives the lowest such index.
- R9: After reset every entry is free: `full` is low, `can_prefetch` is high and `lookup_hit` is low.
- R10: With DEM_RSV = 0, `can_prefetch` is high exactly when the occupancy is less than PHYS - ACC_RSV.

Ports at the default widths: BLK_W = 10, PHYS = 5, so the index is 3 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dem_req_valid | input | 1 | Demand miss requests an entry |
| dem_req_blk | input | BLK_W | Block address of the demand miss |
| dem_req_ready | output | 1 | Demand request accepted this cycle |
| pf_req_valid | input | 1 | Prefetch requests an entry |
| pf_req_blk | input | BLK_W | Block address of the prefetch |
| pf_reject | output | 1 | Prefetch dropped this cycle |
| alloc_idx | output | IDX_W | Entry taken by an accepted allocation |
| dealloc_valid | input | 1 | Release an entry |
| dealloc_idx | input | IDX_W | Index of the entry to release |
| lookup_blk | input | BLK_W | Block address to search for |
| lookup_hit | output | 1 | A valid entry holds the block |
| lookup_idx | output | IDX_W | Lowest matching entry |
| full | output | 1 | Capacity limit reached |
| can_prefetch | output | 1 | Prefetch admission open |

## Verification
A wrong occupancy count shows on the next cycle at `full` or `can_prefetch`, but only once the count moves across one of the two thresholds. The bench therefore sweeps the occupancy through every value it can take, from empty up to the full limit, and checks both flags at each step. A lost or stray valid bit shows at the lookup port and at `alloc_idx` in the cycle after the faulty update. To catch it, the bench looks up every block it holds, checks which index each allocation receives, and runs a long pseudo-random mix of requests and releases against an arithmetic model.

// File: rtl/mshr_pool_pkg.sv
package mshr_pool_pkg;
    localparam int DEF_N_CFG   = 4;
    localparam int DEF_ACC_RSV = 2;
    localparam int DEF_DEM_RSV = 1;
    localparam int DEF_BLK_W   = 10;

    function automatic int phys_entries(input int n_cfg, input int acc_rsv);
        return n_cfg + acc_rsv - 1;
    endfunction
endpackage

// File: rtl/mshr_pick_first.sv
module mshr_pick_first #(
    parameter int W  = 5,
    parameter int IW = 3
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/mshr_occupancy.sv
module mshr_occupancy #(
    parameter int PHYS_N  = 5,
    parameter int ACC_RSV = 2,
    parameter int DEM_RSV = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic full,
    output logic can_pf
);
    localparam int CNT_W = $clog2(PHYS_N + 1);
    localparam logic [CNT_W-1:0] FULL_LIM = CNT_W'(PHYS_N - ACC_RSV);
    localparam logic [CNT_W-1:0] PF_LIM   = CNT_W'(PHYS_N - ACC_RSV - DEM_RSV);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(PHYS_N - ACC_RSV + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } occ_state_t;

    occ_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        st_d.cnt = st_q.cnt + CNT_W'(inc) - CNT_W'(dec);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign full   = st_q.cnt > FULL_LIM;
    assign can_pf = st_q.cnt < PF_LIM;

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_MAX);

    // R3
    pf_inside_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        can_pf |-> !full);

    // R7
    inc_dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && dec) |=> $stable(st_q.cnt));
endmodule

// File: rtl/mshr_entry_array.sv
module mshr_entry_array #(
    parameter int PHYS_N = 5,
    parameter int BLK_W  = 10,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [BLK_W-1:0] alloc_blk,
    input  logic             dealloc_en,
    input  logic [IDX_W-1:0] dealloc_idx,
    input  logic [BLK_W-1:0] lookup_blk,
    output logic             free_found,
    output logic [IDX_W-1:0] free_idx,
    output logic             dealloc_hit,
    output logic             lookup_hit,
    output logic [IDX_W-1:0] lookup_idx
);
    typedef struct packed {
        logic             valid;
        logic [BLK_W-1:0] blk;
    } entry_t;

    typedef struct packed {
        entry_t [PHYS_N-1:0] ent;
    } arr_state_t;

    arr_state_t st_q, st_d;

    logic [PHYS_N-1:0] free_vec;
    logic [PHYS_N-1:0] match_vec;
    logic [PHYS_N-1:0] rel_vec;

    for (genvar g = 0; g < PHYS_N; g++) begin : g_ent
        assign free_vec[g]  = !st_q.ent[g].valid;
        assign match_vec[g] = st_q.ent[g].valid && (st_q.ent[g].blk == lookup_blk);
        assign rel_vec[g]   = dealloc_en && st_q.ent[g].valid
                              && (dealloc_idx == IDX_W'(g));
    end

    mshr_pick_first #(.W(PHYS_N), .IW(IDX_W)) u_free_pick (
        .req   (free_vec),
        .found (free_found),
        .idx   (free_idx)
    );

    mshr_pick_first #(.W(PHYS_N), .IW(IDX_W)) u_match_pick (
        .req   (match_vec),
        .found (lookup_hit),
        .idx   (lookup_idx)
    );

    assign dealloc_hit = |rel_vec;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < PHYS_N; i++) begin
            if (rel_vec[i]) st_d.ent[i].valid = 1'b0;
        end
        if (alloc_en) begin
            for (int i = 0; i < PHYS_N; i++) begin
                if (free_idx == IDX_W'(i)) begin
                    st_d.ent[i].valid = 1'b1;
                    st_d.ent[i].blk   = alloc_blk;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R1
    alloc_to_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (free_found && (free_vec & ~rel_vec) != '0));

    // R8
    lookup_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_hit |-> (match_vec != '0));

    // R6
    release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dealloc_hit && !alloc_en) |=> $countones(free_vec) == $past($countones(free_vec)) + 1);
endmodule

// File: rtl/mshr_pool.sv
module mshr_pool
    import mshr_pool_pkg::*;
#(
    parameter int N_CFG   = DEF_N_CFG,
    parameter int ACC_RSV = DEF_ACC_RSV,
    parameter int DEM_RSV = DEF_DEM_RSV,
    parameter int BLK_W   = DEF_BLK_W,
    localparam int PHYS_N = phys_entries(N_CFG, ACC_RSV),
    localparam int IDX_W  = (PHYS_N > 1) ? $clog2(PHYS_N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dem_req_valid,
    input  logic [BLK_W-1:0] dem_req_blk,
    output logic             dem_req_ready,
    input  logic             pf_req_valid,
    input  logic [BLK_W-1:0] pf_req_blk,
    output logic             pf_reject,
    output logic [IDX_W-1:0] alloc_idx,
    input  logic             dealloc_valid,
    input  logic [IDX_W-1:0] dealloc_idx,
    input  logic [BLK_W-1:0] lookup_blk,
    output logic             lookup_hit,
    output logic [IDX_W-1:0] lookup_idx,
    output logic             full,
    output logic             can_prefetch
);
    if (ACC_RSV + DEM_RSV >= PHYS_N) begin : g_bad_cfg
        $error("mshr_pool: reserves leave no entry for prefetch");
    end

    typedef struct packed {
        logic             dem_fire;
        logic             pf_fire;
        logic             alloc_en;
        logic [BLK_W-1:0] alloc_blk;
    } sel_t;

    sel_t sel;
    logic free_found;
    logic dealloc_hit;

    always_comb begin
        sel           = '0;
        sel.dem_fire  = dem_req_valid && !full && free_found;
        sel.pf_fire   = pf_req_valid && !dem_req_valid && can_prefetch && free_found;
        sel.alloc_en  = sel.dem_fire || sel.pf_fire;
        sel.alloc_blk = dem_req_valid ? dem_req_blk : pf_req_blk;
    end

    assign dem_req_ready = !full;
    assign pf_reject     = pf_req_valid && !sel.pf_fire;

    mshr_entry_array #(.PHYS_N(PHYS_N), .BLK_W(BLK_W), .IDX_W(IDX_W)) u_arr (
        .clk         (clk),
        .rst_n       (rst_n),
        .alloc_en    (sel.alloc_en),
        .alloc_blk   (sel.alloc_blk),
        .dealloc_en  (dealloc_valid),
        .dealloc_idx (dealloc_idx),
        .lookup_blk  (lookup_blk),
        .free_found  (free_found),
        .free_idx    (alloc_idx),
        .dealloc_hit (dealloc_hit),
        .lookup_hit  (lookup_hit),
        .lookup_idx  (lookup_idx)
    );

    mshr_occupancy #(.PHYS_N(PHYS_N), .ACC_RSV(ACC_RSV), .DEM_RSV(DEM_RSV)) u_occ (
        .clk    (clk),
        .rst_n  (rst_n),
        .inc    (sel.alloc_en),
        .dec    (dealloc_hit),
        .full   (full),
        .can_pf (can_prefetch)
    );

    // R4
    blocked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dem_req_valid && !dem_req_ready && !dealloc_valid) |=> (full && !can_prefetch));

    // R5
    pf_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_reject && !dem_req_valid) |-> !can_prefetch);
endmodule

// File: tb/mshr_pool_test.sv
`timescale 1ns/1ps
module mshr_pool_test;
    localparam int N_CFG = 4, ACC = 2, DEM = 1, BW = 10;
    localparam int PHYS = N_CFG + ACC - 1;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          dem_v, pf_v, dl_v;
    logic [BW-1:0] dem_b, pf_b, lk_b;
    logic [IW-1:0] dl_i;
    logic          dem_rdy, pf_rej, lk_hit, full_o, canpf_o;
    logic [IW-1:0] al_idx, lk_idx;
    logic          w_rdy, w_rej, w_hit, w_full, w_canpf;
    logic [IW-1:0] w_al, w_lk;

    mshr_pool #(.N_CFG(N_CFG), .ACC_RSV(ACC), .DEM_RSV(DEM), .BLK_W(BW)) uut (
        .clk(clk), .rst_n(rst_n),
        .dem_req_valid(dem_v), .dem_req_blk(dem_b), .dem_req_ready(dem_rdy),
        .pf_req_valid(pf_v), .pf_req_blk(pf_b), .pf_reject(pf_rej),
        .alloc_idx(al_idx), .dealloc_valid(dl_v), .dealloc_idx(dl_i),
        .lookup_blk(lk_b), .lookup_hit(lk_hit), .lookup_idx(lk_idx),
        .full(full_o), .can_prefetch(canpf_o));

    mshr_pool #(.N_CFG(N_CFG), .ACC_RSV(ACC), .DEM_RSV(0), .BLK_W(BW)) uut_wb (
        .clk(clk), .rst_n(rst_n),
        .dem_req_valid(dem_v), .dem_req_blk(dem_b), .dem_req_ready(w_rdy),
        .pf_req_valid(pf_v), .pf_req_blk(pf_b), .pf_reject(w_rej),
        .alloc_idx(w_al), .dealloc_valid(dl_v), .dealloc_idx(dl_i),
        .lookup_blk(lk_b), .lookup_hit(w_hit), .lookup_idx(w_lk),
        .full(w_full), .can_prefetch(w_canpf));

    int checks = 0, errors = 0;
    bit mv [PHYS];
    int mb [PHYS];
    int cnt = 0;
    bit wb_sync = 1'b1;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit dv, input int db, input bit pv, input int pb,
                        input bit lv, input int li, input int lb, input string lk_tag);
        int fr, hi;
        bit efull, ecan, dfire, pfire, rel;
        @(negedge clk);
        dem_v = dv; dem_b = BW'(db); pf_v = pv; pf_b = BW'(pb);
        dl_v = lv; dl_i = IW'(li); lk_b = BW'(lb);
        #1;
        efull = cnt > PHYS - ACC;
        ecan  = cnt < PHYS - ACC - DEM;
        fr = -1; hi = -1;
        for (int i = PHYS - 1; i >= 0; i--) begin
            if (!mv[i]) fr = i;
            if (mv[i] && mb[i] == lb) hi = i;
        end
        dfire = dv && !efull;
        pfire = pv && !dv && ecan;
        chk("R2 full", int'(full_o), int'(efull));
        chk("R2 ready", int'(dem_rdy), int'(!efull));
        chk("R3 can_prefetch", int'(canpf_o), int'(ecan));
        if (pv) chk("R5 pf_reject", int'(pf_rej), int'(!pfire));
        chk({lk_tag, " lookup_hit"}, int'(lk_hit), int'(hi >= 0));
        if (hi >= 0) chk({lk_tag, " lookup_idx"}, int'(lk_idx), hi);
        if (dfire || pfire) chk(lv ? "R7 alloc_idx" : "R1 alloc_idx", int'(al_idx), fr);
        if (wb_sync) chk("R10 wb can_prefetch", int'(w_canpf), int'(cnt < PHYS - ACC));
        @(posedge clk);
        rel = lv && li < PHYS && mv[li];
        if (rel) begin mv[li] = 1'b0; cnt--; end
        if (dfire || pfire) begin mv[fr] = 1'b1; mb[fr] = dv ? db : pb; cnt++; end
    endtask

    task automatic idle_look(input int lb, input string tag);
        step(0, 0, 0, 0, 0, 0, lb, tag);
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        dem_v = 0; pf_v = 0; dl_v = 0; dem_b = '0; pf_b = '0; dl_i = '0; lk_b = '0;
        for (int i = 0; i < PHYS; i++) begin mv[i] = 0; mb[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R9 full", int'(full_o), 0);
        chk("R9 can_prefetch", int'(canpf_o), 1);
        chk("R9 lookup_hit", int'(lk_hit), 0);

        // demand fill sweep through every occupancy, including rejects at full (R4)
        for (int k = 0; k < 7; k++) step(1, 100 + k, 0, 0, 0, 0, 100 + k - 1, "R8");
        for (int k = 0; k < 7; k++) idle_look(100 + k, "R4");
        wb_sync = 1'b0;
        // release middle entry, check it misses (R6), then refill at lowest free
        step(0, 0, 0, 0, 1, 2, 102, "R8");
        idle_look(102, "R6");
        step(0, 0, 0, 0, 1, 2, 0, "R6");          // release of a free entry ignored
        step(0, 0, 0, 0, 1, 7, 0, "R6");          // out-of-range index ignored
        step(1, 200, 0, 0, 0, 0, 200, "R8");
        idle_look(200, "R1");
        // simultaneous allocate and release at full-1 (R7)
        step(0, 0, 0, 0, 1, 0, 0, "R8");
        step(1, 300, 0, 0, 1, 1, 300, "R7");
        idle_look(101, "R7");
        idle_look(300, "R7");
        // drain
        for (int i = 0; i < PHYS; i++) step(0, 0, 0, 0, 1, i, 0, "R6");
        // prefetch sweep: accepted at 0,1 and rejected from 2 on (R3, R5)
        for (int k = 0; k < 4; k++) step(0, 0, 1, 400 + k, 0, 0, 400 + k, "R5");
        // demand and prefetch together: prefetch dropped
        step(1, 500, 1, 501, 1, 0, 501, "R5");
        idle_look(500, "R5");
        // duplicate blocks: lowest index reported
        step(1, 500, 0, 0, 0, 0, 500, "R8");
        idle_look(500, "R8");
        for (int i = 0; i < PHYS; i++) step(0, 0, 0, 0, 1, i, 0, "R6");

        // pseudo-random mix
        lf = 16'hACE1;
        for (int n = 0; n < 600; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0] & lf[1], 600 + int'(lf[4:2]), lf[5], 600 + int'(lf[8:6]),
                 lf[9] | lf[10], int'(lf[13:11]), 600 + int'(lf[15:13]), "R8");
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule